// File: doc/BRIEF.md
# SPI Interrupt Status and Mask Unit

This unit gathers the interrupt sources of an SPI master controller into a single status word and drives one interrupt line. Three error sources (transmit underflow, receive overflow and mode fail) are latched when their event pulse arrives. They stay set until software clears them by writing ones to the status register. The other four sources are level flags. Each cycle they are worked out from the FIFO fill counts, the FIFO full flags and two programmable thresholds.

Software controls which sources may raise the interrupt through a mask. The mask is never written directly. Writing the enable register sets mask bits, and writing the disable register clears them. The interrupt line is high while any source is both pending and unmasked. Register access is a single-cycle write strobe with a combinational read of the addressed register.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Register addresses on reg_addr_i: 0 status, 1 enable, 2 disable, 3 mask, 4 TX threshold, 5 RX threshold. Status bit layout: bit0 RX overflow, bit1 mode fail, bit2 TX below threshold, bit3 TX full, bit4 RX at or above threshold, bit5 RX full, bit6 TX underflow. Bit 7 and addresses 6 and 7 read as 0.
- R2: A pulse on tx_underflow_i, rx_overflow_i or mode_fail_i sets status bit 6, 0 or 1 respectively on the next edge. The bit stays set until software clears it.
- R3: A write to the status register clears each sticky bit whose write-data bit is 1. Bits written as 0 are kept, and written bits 2–5 and 7 have no effect.
- R4: When an event pulse arrives in the same cycle as a software clear of its bit, the bit stays set.
- R5: Status bit 5 equals rx_full_i and status bit 3 equals tx_full_i in the same cycle.
- R6: Status bit 4 is 1 exactly when rx_count_i >= RX threshold. Status bit 2 is 1 exactly when tx_count_i < TX threshold.
- R7: A write to the enable register ORs write-data bits 6:0 into the mask. A write to the disable register clears the written-one bits from the mask. Reading the mask register returns the mask, and reading the enable or disable register returns 0.
- R8: irq_o is 1 exactly when some bit is set in both the mask and the status word.
- R9: After reset both thresholds read 1, the mask reads 0 and the sticky bits read 0.
- R10: Writes to addresses 4 and 5 load the TX and RX thresholds from the low CNT_W write-data bits. The new value takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_count_i | input | CNT_W | TX FIFO fill count |
| rx_count_i | input | CNT_W | RX FIFO fill count |
| tx_full_i | input | 1 | TX FIFO full |
| rx_full_i | input | 1 | RX FIFO full |
| tx_underflow_i | input | 1 | TX underflow event pulse |
| rx_overflow_i | input | 1 | RX overflow event pulse |
| mode_fail_i | input | 1 | Mode fail event pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data of the addressed register |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear write to the status register landing in the same cycle as a new error event for the same bit. Free-running stimulus rarely lines up the write strobe, the data bit and the pulse. The bench builds this case directly for each sticky bit, alongside partial clears that leave some bits pending. It also walks the FIFO counts across each threshold, one below, equal to and one above, after reprogramming the thresholds. A long mixed-traffic phase then compares every cycle against a behavioural model.

// File: rtl/spi_irq_pkg.sv
`timescale 1ns/1ps
package spi_irq_pkg;
  localparam int IRQ_W    = 7;
  localparam int RXOVF_B  = 0;
  localparam int MFAIL_B  = 1;
  localparam int TXLOW_B  = 2;
  localparam int TXFULL_B = 3;
  localparam int RXHIGH_B = 4;
  localparam int RXFULL_B = 5;
  localparam int TXUND_B  = 6;

  typedef enum logic [2:0] {
    ADDR_STATUS  = 3'd0,
    ADDR_ENABLE  = 3'd1,
    ADDR_DISABLE = 3'd2,
    ADDR_MASK    = 3'd3,
    ADDR_TX_THR  = 3'd4,
    ADDR_RX_THR  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/spi_irq_sticky.sv
`timescale 1ns/1ps
module spi_irq_sticky #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // set after clear: an event beats a simultaneous software clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;
  end

  for (genvar k = 0; k < N; k++) begin : g_chk
    assert_event_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[k] |=> q_o[k]);
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o[k] && !clr_i[k]) |=> q_o[k]);
    assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !set_i[k]) |=> !q_o[k]);
  end
endmodule

// File: rtl/spi_irq_level.sv
`timescale 1ns/1ps
module spi_irq_level
  import spi_irq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] tx_count_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] tx_thr_i,
  input  logic [CNT_W-1:0] rx_thr_i,
  input  logic             tx_full_i,
  input  logic             rx_full_i,
  output logic [IRQ_W-1:0] level_o
);
  always_comb begin
    level_o           = '0;
    level_o[TXLOW_B]  = tx_count_i < tx_thr_i;
    level_o[TXFULL_B] = tx_full_i;
    level_o[RXHIGH_B] = rx_count_i >= rx_thr_i;
    level_o[RXFULL_B] = rx_full_i;
  end
endmodule

// File: rtl/spi_irq_thresh.sv
`timescale 1ns/1ps
module spi_irq_thresh
  import spi_irq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  tx_thr_o,
  output logic [CNT_W-1:0]  rx_thr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_thr_o <= CNT_W'(1);
      rx_thr_o <= CNT_W'(1);
    end else if (we_i) begin
      if (addr_i == ADDR_TX_THR) tx_thr_o <= wdata_i[CNT_W-1:0];
      if (addr_i == ADDR_RX_THR) rx_thr_o <= wdata_i[CNT_W-1:0];
    end
  end

  assert_tx_thr_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_TX_THR) |=> tx_thr_o == $past(wdata_i[CNT_W-1:0]));
  assert_rx_thr_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_RX_THR) |=> rx_thr_o == $past(wdata_i[CNT_W-1:0]));
endmodule

// File: rtl/spi_irq_mask.sv
`timescale 1ns/1ps
module spi_irq_mask #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mask_o <= '0;
    else if (set_we_i) mask_o <= mask_o | bits_i;
    else if (clr_we_i) mask_o <= mask_o & ~bits_i;
  end

  for (genvar k = 0; k < W; k++) begin : g_chk
    assert_enable_sets_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_we_i && bits_i[k]) |=> mask_o[k]);
    assert_disable_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_we_i && !set_we_i && bits_i[k]) |=> !mask_o[k]);
    assert_mask_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_we_i && !clr_we_i) |=> $stable(mask_o[k]));
  end
endmodule

// File: rtl/spi_irq_ctrl.sv
`timescale 1ns/1ps
module spi_irq_ctrl
  import spi_irq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  tx_count_i,
  input  logic [CNT_W-1:0]  rx_count_i,
  input  logic              tx_full_i,
  input  logic              rx_full_i,
  input  logic              tx_underflow_i,
  input  logic              rx_overflow_i,
  input  logic              mode_fail_i,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int NSTICKY = 3;

  logic [IRQ_W-1:0]   wbits, level, status, mask;
  logic [NSTICKY-1:0] sticky_set, sticky_clr, sticky_q;
  logic [CNT_W-1:0]   tx_thr, rx_thr;
  logic               wr_status;

  assign wbits     = reg_wdata_i[IRQ_W-1:0];
  assign wr_status = reg_we_i && (reg_addr_i == ADDR_STATUS);

  // sticky slot order: overflow, mode fail, underflow
  assign sticky_set = {tx_underflow_i, mode_fail_i, rx_overflow_i};
  assign sticky_clr = wr_status ? {wbits[TXUND_B], wbits[MFAIL_B], wbits[RXOVF_B]}
                                : '0;

  spi_irq_sticky #(.N(NSTICKY)) u_sticky (
    .clk_i, .rst_ni, .set_i(sticky_set), .clr_i(sticky_clr), .q_o(sticky_q)
  );

  spi_irq_thresh #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_thresh (
    .clk_i, .rst_ni, .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .tx_thr_o(tx_thr), .rx_thr_o(rx_thr)
  );

  spi_irq_level #(.CNT_W(CNT_W)) u_level (
    .tx_count_i, .rx_count_i, .tx_thr_i(tx_thr), .rx_thr_i(rx_thr),
    .tx_full_i, .rx_full_i, .level_o(level)
  );

  spi_irq_mask #(.W(IRQ_W)) u_mask (
    .clk_i, .rst_ni,
    .set_we_i(reg_we_i && reg_addr_i == ADDR_ENABLE),
    .clr_we_i(reg_we_i && reg_addr_i == ADDR_DISABLE),
    .bits_i(wbits), .mask_o(mask)
  );

  always_comb begin
    status          = level;
    status[RXOVF_B] = sticky_q[0];
    status[MFAIL_B] = sticky_q[1];
    status[TXUND_B] = sticky_q[2];
  end

  assign irq_o = |(mask & status);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_STATUS: reg_rdata_o[IRQ_W-1:0] = status;
      ADDR_MASK:   reg_rdata_o[IRQ_W-1:0] = mask;
      ADDR_TX_THR: reg_rdata_o[CNT_W-1:0] = tx_thr;
      ADDR_RX_THR: reg_rdata_o[CNT_W-1:0] = rx_thr;
      default:     reg_rdata_o = '0;
    endcase
  end

  assert_rx_full_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[RXFULL_B] == rx_full_i);
  assert_tx_full_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status[TXFULL_B] == tx_full_i);
  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |-> !irq_o);
  assert_event_visible_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_overflow_i |=> reg_addr_i != ADDR_STATUS || reg_rdata_o[RXOVF_B]);
endmodule

// File: tb/spi_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_irq_ctrl_tb_top;
  localparam int CW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [CW-1:0] tx_count = '0, rx_count = '0;
  logic          tx_full = 1'b0, rx_full = 1'b0;
  logic          ev_und = 1'b0, ev_ovf = 1'b0, ev_mf = 1'b0;
  logic          we = 1'b0;
  logic [2:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // behavioural model state
  int m_sticky = 0, m_mask = 0, m_txthr = 1, m_rxthr = 1;

  always #4 clk = ~clk;

  spi_irq_ctrl #(.CNT_W(CW), .DATA_W(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tx_count_i(tx_count), .rx_count_i(rx_count),
    .tx_full_i(tx_full), .rx_full_i(rx_full), .tx_underflow_i(ev_und),
    .rx_overflow_i(ev_ovf), .mode_fail_i(ev_mf), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic int m_status();
    int s = m_sticky;
    if (int'(tx_count) < m_txthr) s |= 'h04;
    if (tx_full)                  s |= 'h08;
    if (int'(rx_count) >= m_rxthr) s |= 'h10;
    if (rx_full)                  s |= 'h20;
    return s;
  endfunction

  function automatic int m_read(logic [2:0] a);
    case (a)
      3'd0: return m_status();
      3'd3: return m_mask;
      3'd4: return m_txthr;
      3'd5: return m_rxthr;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one cycle: inputs already set at negedge; compare, then commit model at edge
  task automatic cycle(string tag);
    int expr, expi;
    #1;
    expr = m_read(addr);
    expi = ((m_mask & m_status()) != 0) ? 1 : 0;
    check(tag, int'(rdata), expr, "rdata");
    check(tag, int'(irq), expi, "irq");
    @(posedge clk);
    if (we) begin
      case (addr)
        3'd0: m_sticky &= ~(int'(wdata) & 'h43);
        3'd1: m_mask |= int'(wdata) & 'h7f;
        3'd2: m_mask &= ~(int'(wdata) & 'h7f);
        3'd4: m_txthr = int'(wdata);
        3'd5: m_rxthr = int'(wdata);
        default: ;
      endcase
    end
    if (ev_ovf) m_sticky |= 'h01;
    if (ev_mf)  m_sticky |= 'h02;
    if (ev_und) m_sticky |= 'h40;
    @(negedge clk);
    we = 1'b0; ev_und = 1'b0; ev_ovf = 1'b0; ev_mf = 1'b0;
  endtask

  task automatic wr(string tag, logic [2:0] a, logic [DW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    cycle(tag);
  endtask

  task automatic rd(string tag, logic [2:0] a);
    we = 1'b0; addr = a;
    cycle(tag);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R8 actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9 reset values
    rd("R9", 3'd4); rd("R9", 3'd5); rd("R9", 3'd3); rd("R9", 3'd0);
    // R1 unused addresses and enable/disable read 0
    rd("R1", 3'd6); rd("R1", 3'd7); rd("R7", 3'd1); rd("R7", 3'd2);

    // R2 each sticky event sets and holds
    ev_ovf = 1'b1; rd("R2", 3'd0);
    rd("R2", 3'd0);
    ev_mf = 1'b1; rd("R2", 3'd0);
    ev_und = 1'b1; rd("R2", 3'd0);
    rd("R2", 3'd0); rd("R2", 3'd0);

    // R3 partial clear, non-sticky and bit7 writes ignored
    wr("R3", 3'd0, 8'hBC); rd("R3", 3'd0);
    wr("R3", 3'd0, 8'h02); rd("R3", 3'd0);
    wr("R3", 3'd0, 8'h41); rd("R3", 3'd0);

    // R4 event same cycle as clear, each bit
    ev_ovf = 1'b1; rd("R4", 3'd0);
    ev_ovf = 1'b1; wr("R4", 3'd0, 8'h01); rd("R4", 3'd0);
    ev_mf = 1'b1; ev_und = 1'b1; wr("R4", 3'd0, 8'h43); rd("R4", 3'd0);
    wr("R3", 3'd0, 8'h43); rd("R3", 3'd0);

    // R5 full flags
    tx_full = 1'b1; rd("R5", 3'd0);
    rx_full = 1'b1; rd("R5", 3'd0);
    tx_full = 1'b0; rd("R5", 3'd0);
    rx_full = 1'b0; rd("R5", 3'd0);

    // R10 / R6 threshold programming and boundaries
    wr("R10", 3'd4, 8'd10); rd("R10", 3'd4);
    wr("R10", 3'd5, 8'd20); rd("R10", 3'd5);
    for (int c = 8; c <= 12; c++) begin tx_count = CW'(c); rd("R6", 3'd0); end
    for (int c = 18; c <= 22; c++) begin rx_count = CW'(c); rd("R6", 3'd0); end
    wr("R10", 3'd5, 8'd0); rx_count = '0; rd("R6", 3'd0);
    wr("R10", 3'd4, 8'd0); tx_count = '0; rd("R6", 3'd0);
    wr("R10", 3'd4, 8'hFF); tx_count = 8'hFE; rd("R6", 3'd0);
    tx_count = 8'hFF; rd("R6", 3'd0);

    // R7 mask via enable/disable
    wr("R7", 3'd1, 8'h05); rd("R7", 3'd3);
    wr("R7", 3'd1, 8'hF0); rd("R7", 3'd3);
    wr("R7", 3'd2, 8'h14); rd("R7", 3'd3);
    rd("R7", 3'd1); rd("R7", 3'd2);

    // R8 interrupt follows mask & status
    wr("R7", 3'd2, 8'h7F);
    ev_und = 1'b1; rd("R8", 3'd0);
    wr("R8", 3'd1, 8'h40); rd("R8", 3'd0);
    wr("R8", 3'd0, 8'h40); rd("R8", 3'd0);
    rx_full = 1'b1; wr("R8", 3'd1, 8'h20); rd("R8", 3'd0);
    rx_full = 1'b0; rd("R8", 3'd0);

    // mixed traffic, compared every cycle
    for (int i = 0; i < 3000; i++) begin
      tx_count = CW'($urandom_range(0, 24));
      rx_count = CW'($urandom_range(0, 24));
      tx_full  = ($urandom_range(0, 7) == 0);
      rx_full  = ($urandom_range(0, 7) == 0);
      ev_und   = ($urandom_range(0, 9) == 0);
      ev_ovf   = ($urandom_range(0, 9) == 0);
      ev_mf    = ($urandom_range(0, 9) == 0);
      we       = ($urandom_range(0, 3) == 0);
      addr     = 3'($urandom_range(0, 7));
      wdata    = (addr >= 3'd4) ? DW'($urandom_range(0, 24)) : DW'($urandom);
      cycle("R8");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule